// File: doc/BRIEF.md
# USB End-of-Packet Detector

This block watches the two single-ended line samples of a USB receiver, taken at a fixed oversampling clock, and finds the end of each packet. A packet ends when both lines are held low (single-ended zero, SE0) for a minimum time and the bus then returns to the idle J state. When that happens the block raises a one-cycle end-of-packet strobe. A downstream packet decoder uses this strobe to close the current packet.

If the line leaves a valid SE0 for anything other than J, the block does not hang waiting for J. It still raises the end-of-packet strobe, so the packet is passed on and the next one can be caught. Alongside the strobe it raises a possible-bad-EOP flag and drives a 6-bit status code. A speed input selects the timing and the J polarity:

- At full speed the minimum SE0 is 60 ns and J is D+ high, D- low.
- At low speed the minimum SE0 is 300 ns and J is D- high, D+ low.

The minimum sample counts come from the sample period parameter, rounded up. The default period of 20 ns gives 3 samples at full speed and 15 at low speed. The 3-bit state is brought out so the detector can be observed.

Top module: `usb_eop_detector`

## Requirements
- R1: After reset, the state is IDLE (000), both strobes are low and the status is 000000.
- R2: At full speed, an SE0 of at least 3 samples followed by a J sample (dp=1, dm=0) raises eop_o, with bad_eop_o low, in the cycle after the J sample.
- R3: At low speed, an SE0 of at least 15 samples followed by a J sample (dp=0, dm=1) raises eop_o, with bad_eop_o low, in the cycle after the J sample.
- R4: An SE0 shorter than the minimum for its speed returns the state to IDLE with no strobe.
- R5: A valid SE0 followed by a sample that is neither SE0 nor J (K or both lines high) raises both eop_o and bad_eop_o for one cycle. During that cycle status_o reads 110111.
- R6: After an end-of-packet state (EOPR or BAD_EOPR), the state is IDLE on the next sample. The line sample taken in that cycle is ignored, and every strobe lasts exactly one cycle.
- R7: state_o follows these codes. IDLE is 000. Full-speed SE0 counting goes 100 on the first sample, 010 on the second and 110 on the third and later. Low-speed SE0 counting is 101 on the first sample and 011 after that. EOPR is 001 and BAD_EOPR is 111.
- R8: The speed sampled on the first SE0 sample selects the minimum length and the state family for that SE0. The J polarity is judged with the speed input at the sample that ends the SE0.
- R9: status_o is 000000 in every cycle where bad_eop_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock; one line sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| low_speed_i | input | 1 | 1 selects low-speed timing and J polarity |
| dp_i | input | 1 | Sampled D+ receiver output |
| dm_i | input | 1 | Sampled D- receiver output |
| eop_o | output | 1 | One-cycle end-of-packet strobe |
| bad_eop_o | output | 1 | One-cycle possible-bad-EOP flag |
| status_o | output | 6 | 110111 while bad_eop_o is high, otherwise 0 |
| state_o | output | 3 | Current detector state code |

## Verification
Each line sample is registered once, so every output reflects the sample taken at the preceding rising edge. The strobes and status appear exactly one cycle after the sample that ends the SE0. The return to IDLE is seen one cycle after that.

The bench drives each sample at a falling edge. It advances its own model on the next rising edge and compares all four outputs at the following falling edge, so each check lands in the cycle its result is due. Directed runs sit exactly on and one sample under each minimum, and random segments mix speeds, SE0 lengths and end symbols.

// File: rtl/usb_eop_detector.sv
module usb_eop_detector #(
  parameter int SAMPLE_PS = 20000,
  parameter int FS_SE0_PS = 60000,
  parameter int LS_SE0_PS = 300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       low_speed_i,
  input  logic       dp_i,
  input  logic       dm_i,
  output logic       eop_o,
  output logic       bad_eop_o,
  output logic [5:0] status_o,
  output logic [2:0] state_o
);

  localparam int FS_MIN  = (FS_SE0_PS + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int LS_MIN  = (LS_SE0_PS + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int CNT_MAX = (FS_MIN > LS_MIN) ? FS_MIN : LS_MIN;
  localparam int CW      = $clog2(CNT_MAX + 1);

  localparam logic [2:0] ST_IDLE  = 3'b000;
  localparam logic [2:0] ST_F1    = 3'b100;
  localparam logic [2:0] ST_F2    = 3'b010;
  localparam logic [2:0] ST_F3    = 3'b110;
  localparam logic [2:0] ST_EOP   = 3'b001;
  localparam logic [2:0] ST_S1    = 3'b101;
  localparam logic [2:0] ST_S2    = 3'b011;
  localparam logic [2:0] ST_BAD   = 3'b111;
  localparam logic [5:0] BAD_CODE = 6'b110111;

  logic [2:0]    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  wire se0       = !dp_i && !dm_i;
  wire is_j      = low_speed_i ? (!dp_i && dm_i) : (dp_i && !dm_i);
  wire slow_fam  = (state_q == ST_S1) || (state_q == ST_S2);
  wire fast_fam  = (state_q == ST_F1) || (state_q == ST_F2) || (state_q == ST_F3);
  wire in_se0    = slow_fam || fast_fam;
  wire long_fast = cnt_q >= CW'(FS_MIN);
  wire long_slow = cnt_q >= CW'(LS_MIN);
  wire se0_valid = slow_fam ? long_slow : long_fast;
  wire [CW-1:0] cnt_inc = (cnt_q == CW'(CNT_MAX)) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (state_q == ST_IDLE) begin
      if (se0) begin
        state_d = low_speed_i ? ST_S1 : ST_F1;
        cnt_d   = CW'(1);
      end
    end else if (in_se0) begin
      if (se0) begin
        cnt_d = cnt_inc;
        case (state_q)
          ST_F1:   state_d = ST_F2;
          ST_F2:   state_d = ST_F3;
          ST_S1:   state_d = ST_S2;
          default: state_d = state_q;
        endcase
      end else begin
        cnt_d = '0;
        if (!se0_valid) state_d = ST_IDLE;
        else            state_d = is_j ? ST_EOP : ST_BAD;
      end
    end else begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign eop_o     = (state_q == ST_EOP) || (state_q == ST_BAD);
  assign bad_eop_o = (state_q == ST_BAD);
  assign status_o  = bad_eop_o ? BAD_CODE : 6'b000000;
  assign state_o   = state_q;

  AST_EOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> !eop_o); // R6
  AST_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> (state_o == ST_IDLE)); // R6
  AST_BAD_WITH_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    bad_eop_o |-> eop_o); // R5
  AST_EOP_AFTER_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eop_o) |-> $past(in_se0) && !$past(se0)); // R2
  AST_GOOD_NEEDS_J: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eop_o) && !bad_eop_o |-> $past(is_j)); // R3
  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_eop_o |-> (status_o == 6'b000000)); // R9

endmodule

// File: tb/usb_eop_detector_tb.sv
module usb_eop_detector_tb;
  localparam int FS_N = 3;
  localparam int LS_N = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ls = 1'b0, dp = 1'b1, dm = 1'b0;
  logic eop, bad;
  logic [5:0] status;
  logic [2:0] state;

  int checks = 0, fails = 0, cycles = 0;
  int rc = 0;
  bit lat = 0, m_end = 0, m_bad = 0;
  string note = "";

  always #4 clk = ~clk;

  usb_eop_detector u_dut (
    .clk(clk), .rst_n(rst_n), .low_speed_i(ls), .dp_i(dp), .dm_i(dm),
    .eop_o(eop), .bad_eop_o(bad), .status_o(status), .state_o(state)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, note, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [2:0] exp_state();
    if (m_end) return m_bad ? 3'b111 : 3'b001;
    if (rc == 0) return 3'b000;
    if (lat) return (rc == 1) ? 3'b101 : 3'b011;
    if (rc == 1) return 3'b100;
    if (rc == 2) return 3'b010;
    return 3'b110;
  endfunction

  task automatic model(bit s_ls, bit s_dp, bit s_dm);
    bit se0 = !s_dp && !s_dm;
    bit j = s_ls ? (!s_dp && s_dm) : (s_dp && !s_dm);
    if (m_end) begin
      m_end = 0; m_bad = 0; rc = 0;
    end else if (se0) begin
      if (rc == 0) lat = s_ls;
      rc++;
    end else begin
      if (rc > 0 && rc >= (lat ? LS_N : FS_N)) begin
        m_end = 1; m_bad = !j;
      end
      rc = 0;
    end
  endtask

  // sym: 0 = SE0, 1 = J, 2 = K, 3 = SE1 ; J/K polarity by s_ls
  task automatic step(bit s_ls, int sym);
    string t;
    ls = s_ls;
    case (sym)
      0: begin dp = 0; dm = 0; end
      1: begin dp = !s_ls; dm = s_ls; end
      2: begin dp = s_ls; dm = !s_ls; end
      default: begin dp = 1; dm = 1; end
    endcase
    @(posedge clk);
    model(s_ls, dp, dm);
    @(negedge clk);
    t = m_bad ? "R5" : (m_end ? (lat ? "R3" : "R2") : "R4");
    check(t, {7'd0, eop}, {7'd0, m_end});
    check(m_bad ? "R5" : "R6", {7'd0, bad}, {7'd0, m_bad});
    check(m_bad ? "R5" : "R9", {2'd0, status}, m_bad ? 8'h37 : 8'h00);
    check("R7", {5'd0, state}, {5'd0, exp_state()});
  endtask

  task automatic frame(bit s_ls, int n, int last);
    for (int i = 0; i < n; i++) step(s_ls, 0);
    step(s_ls, last);
    step(s_ls, 1);
    step(s_ls, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", {5'd0, state}, 8'h00);
    check("R1", {7'd0, eop}, 8'h00);
    check("R1", {7'd0, bad}, 8'h00);
    check("R1", {2'd0, status}, 8'h00);

    note = "fs exact min";       frame(0, FS_N, 1);
    note = "fs one short";       frame(0, FS_N - 1, 1);
    note = "fs long then K";     frame(0, FS_N + 2, 2);
    note = "fs then SE1";        frame(0, FS_N + 1, 3);
    note = "ls exact min";       frame(1, LS_N, 1);
    note = "ls one short";       frame(1, LS_N - 1, 1);
    note = "ls short by fs rule"; frame(1, FS_N, 1);
    note = "ls then K";          frame(1, LS_N + 1, 2);
    note = "R8 speed latched at start";
    for (int i = 0; i < FS_N; i++) step(0, 0);
    for (int i = 0; i < 2; i++) step(1, 0);
    step(1, 1);
    step(0, 1);
    note = "R6 SE0 right after strobe ignored";
    for (int i = 0; i < FS_N; i++) step(0, 0);
    step(0, 1);
    step(0, 0);
    step(0, 0);
    step(0, 1);
    step(0, 1);

    note = "random";
    for (int s = 0; s < 2500; s++) begin
      bit rl = $urandom_range(1, 0) == 1;
      int n = $urandom_range(20, 0);
      frame(rl, n, $urandom_range(3, 1));
      if ($urandom_range(3, 0) == 0) step(rl, 0);
    end
    finish_run();
  end
endmodule